// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block runs one external memory cycle per request over a narrow multiplexed bus. One 8-bit port carries the low address byte and then the data byte of the same cycle. A second 8-bit port carries the high address byte for the whole cycle. A latch enable tells the board-level address latch when to capture the low byte. Separate active-low strobes mark reads of data memory, writes of data memory and code fetches.

Every cycle lasts six CPU states. A CPU state is two oscillator clocks in standard mode and one oscillator clock in double-speed mode, so a cycle takes 12 or 6 clocks of `clk`. The mode is sampled when a request is accepted.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it likes, and nothing is lost while `req_ready` is low. The result side cannot apply back-pressure. `done` pulses for one clock, and `rd_data` and `rsp_offchip` stay valid from that pulse until the next cycle ends.

Top module: `xbus_mux_if`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1. It is 0 from the clock after acceptance until after the `done` pulse, and it returns to 1 in the clock that follows `done`.
- R2: `done` is high in the last oscillator clock of the sixth state. Taking the acceptance edge as edge 0, that is after edge 11 in standard mode (`dbl_speed`=0) and after edge 5 in double-speed mode (`dbl_speed`=1).
- R3: During a cycle, `hi_out` carries bits 15:8 of the accepted address in every state, even if the request inputs change.
- R4: In an off-chip cycle, `ale` is 1 during state 1 only. `lo_oe` is 1 and `lo_out` carries address bits 7:0 during states 1 and 2.
- R5: In an off-chip read or fetch, `lo_oe` is 0 in states 3 to 6. `rd_data` takes the value of `lo_in` from the last clock of state 5. A change on `lo_in` during state 6 does not reach `rd_data`.
- R6: In a write (`req_kind`=2), `wr_n` is 0 in states 3 to 5. `lo_oe` is 1 and `lo_out` carries the write data in states 3 to 6, so the data stays on the port after `wr_n` rises.
- R7: In a data read (`req_kind`=1, and also the reserved code 3), `rd_n` is 0 in states 3 to 5, and `wr_n` and `psen_n` stay 1.
- R8: In a code fetch (`req_kind`=0), `rd_n` and `wr_n` stay 1. If the fetch goes off-chip, `psen_n` is 0 in states 3 to 5.
- R9: When `force_ext_n` is 0, every code fetch goes off-chip, including address 0. When it is 1, a fetch below `INT_CODE_BYTES` (default 8192) produces no `ale`, no `psen_n` and no port drive. `done` still comes at the usual time, with `rsp_offchip`=0, and `rd_data` keeps its previous value. Data cycles always go off-chip with `rsp_offchip`=1.
- R10: Changing `dbl_speed` after acceptance does not change the length of the running cycle.
- R11: In reset, `ale`=0, `rd_n`=`wr_n`=`psen_n`=1, `lo_oe`=0 and `done`=0.
- R12: `done` is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 treated as read |
| dbl_speed | input | 1 | 1: one clock per CPU state, 0: two |
| force_ext_n | input | 1 | Low: all code fetches go off-chip |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 8 | Byte captured from the bus |
| rsp_offchip | output | 1 | Last cycle used the external bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program fetch strobe, active low |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port drive enable; 0 means the port floats |
| lo_in | input | 8 | Low port sampled value |
| hi_out | output | 8 | High address byte |

## Verification
The hardest point to reach is the read capture. The byte has to be taken in the last clock of state 5 and not one clock later, and a bench that holds `lo_in` steady cannot tell those two apart. The stimulus therefore puts the expected byte on `lo_in` up to the end of state 5 and its complement in state 6, in both speed modes. It also flips `dbl_speed` and the request fields right after acceptance, which shows whether the mode and the address were latched or are still being read live.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_CODE  = 2'd0,
    XK_READ  = 2'd1,
    XK_WRITE = 2'd2,
    XK_RSVD  = 2'd3
  } xkind_e;

  // CPU states per external cycle and the phase map inside one cycle
  localparam int unsigned XB_STATES    = 6;
  localparam int unsigned XB_ADDR_LAST = 1;  // states 0..1 carry the low address
  localparam int unsigned XB_STB_FIRST = 2;  // strobes active in states 2..4
  localparam int unsigned XB_STB_LAST  = 4;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int unsigned STATES = xbus_pkg::XB_STATES,
  localparam int unsigned SW = $clog2(STATES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbl_in,
  output logic          busy,
  output logic [SW-1:0] st,
  output logic          tick_last,
  output logic          cyc_end
);
  logic          busy_q;
  logic [SW-1:0] st_q;
  logic          sub_q;
  logic          dbl_q;

  assign tick_last = dbl_q | sub_q;
  assign busy      = busy_q;
  assign st        = st_q;
  assign cyc_end   = busy_q && tick_last && (st_q == SW'(STATES-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      st_q   <= '0;
      sub_q  <= 1'b0;
      dbl_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      st_q   <= '0;
      sub_q  <= 1'b0;
      dbl_q  <= dbl_in;
    end else if (busy_q) begin
      if (tick_last) begin
        sub_q <= 1'b0;
        if (st_q == SW'(STATES-1)) busy_q <= 1'b0;
        else                       st_q   <= st_q + 1'b1;
      end else begin
        sub_q <= 1'b1;
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);  // R1
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (st_q < SW'(STATES)));  // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(start)) |-> $stable(dbl_q));  // R10
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SW    = $clog2(XB_STATES),
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              busy,
  input  logic [SW-1:0]     st,
  input  xkind_e            kind,
  input  logic              offchip,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out
);
  logic in_addr, in_stb, is_code, is_wr, is_rd, bus_on;

  always_comb begin
    in_addr = (st <= SW'(XB_ADDR_LAST));
    in_stb  = (st >= SW'(XB_STB_FIRST)) && (st <= SW'(XB_STB_LAST));
    is_code = (kind == XK_CODE);
    is_wr   = (kind == XK_WRITE);
    is_rd   = !is_code && !is_wr;
    bus_on  = busy && offchip;

    ale    = bus_on && (st == '0);
    lo_oe  = bus_on && (in_addr || is_wr);
    lo_out = in_addr ? addr[DATA_W-1:0] : wdata;
    hi_out = addr[ADDR_W-1:DATA_W];
    psen_n = !(bus_on && is_code && in_stb);
    rd_n   = !(bus_on && is_rd && in_stb);
    wr_n   = !(bus_on && is_wr && in_stb);
  end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (sample) rd_data <= lo_in;
  end
endmodule

// File: rtl/xbus_mux_if.sv
module xbus_mux_if
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned INT_CODE_BYTES = 8192,
  localparam int unsigned SW            = $clog2(XB_STATES),
  localparam int unsigned HI_W          = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_kind,
  input  logic              dbl_speed,
  input  logic              force_ext_n,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rsp_offchip,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  input  logic [DATA_W-1:0] lo_in,
  output logic [HI_W-1:0]   hi_out
);
  localparam logic [ADDR_W:0] INT_LIM = (ADDR_W+1)'(INT_CODE_BYTES);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    xkind_e            kind;
  } xreq_t;

  xreq_t         cur_q;
  logic          off_q;
  logic          start, busy, tick_last, off_d, sample;
  logic [SW-1:0] st;

  assign req_ready   = !busy;
  assign start       = req_valid && req_ready;
  assign rsp_offchip = off_q;
  assign off_d = (xkind_e'(req_kind) != XK_CODE) || !force_ext_n ||
                 ({1'b0, req_addr} >= INT_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '{addr: '0, wdata: '0, kind: XK_CODE};
      off_q <= 1'b0;
    end else if (start) begin
      cur_q <= '{addr: req_addr, wdata: req_wdata, kind: xkind_e'(req_kind)};
      off_q <= off_d;
    end
  end

  xbus_seq #(.STATES(XB_STATES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl_in(dbl_speed),
    .busy(busy), .st(st), .tick_last(tick_last), .cyc_end(done)
  );

  xbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drv_i (
    .busy(busy), .st(st), .kind(cur_q.kind), .offchip(off_q),
    .addr(cur_q.addr), .wdata(cur_q.wdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out)
  );

  assign sample = busy && off_q && (cur_q.kind != XK_WRITE) && tick_last &&
                  (st == SW'(XB_STB_LAST));

  xbus_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .sample(sample), .lo_in(lo_in), .rd_data(rd_data)
  );

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);  // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R12
  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(hi_out));  // R3
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && psen_n && lo_oe));  // R4
  AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !lo_oe);  // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> lo_oe);  // R6
  AST_CODE_NO_DATA_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));  // R8
endmodule

// File: tb/xbus_mux_if_tb_top.sv
`timescale 1ns/1ps
module xbus_mux_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic [1:0] req_kind;
  logic       dbl_speed, force_ext_n;
  logic       done, rsp_offchip, ale, rd_n, wr_n, psen_n, lo_oe;
  logic [7:0] rd_data, lo_out, lo_in, hi_out;

  always #2 clk = ~clk;  // 250 MHz

  xbus_mux_if dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_kind(req_kind),
    .dbl_speed(dbl_speed), .force_ext_n(force_ext_n), .done(done),
    .rd_data(rd_data), .rsp_offchip(rsp_offchip), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .psen_n(psen_n), .lo_out(lo_out), .lo_oe(lo_oe),
    .lo_in(lo_in), .hi_out(hi_out)
  );

  typedef struct {
    logic [7:0] rd;
    logic       ext;
    int         len;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0, t_acc = 0;
  logic [7:0] last_rd = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && req_valid && req_ready) t_acc <= cyc + 1;
  end

  // Monitor: pops the scoreboard at each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk("R2 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk("R2 cycle length", cyc - t_acc, e.len - 1);
        chk("R9 offchip flag", rsp_offchip, e.ext);
        chk("R5 read data", rd_data, e.rd);
      end
    end
  end

  // Driver: one request, checked state by state
  task automatic run_cycle(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic dbl,
                           input logic fe_n, input logic [7:0] rv);
    int k;
    logic ext, is_w, is_c, is_r;
    exp_t e;
    k    = dbl ? 1 : 2;
    is_c = (kind == 2'd0);
    is_w = (kind == 2'd2);
    is_r = !is_c && !is_w;
    ext  = !is_c || !fe_n || (addr >= 16'd8192);
    req_valid = 1; req_addr = addr; req_wdata = wd; req_kind = kind;
    dbl_speed = dbl; force_ext_n = fe_n; lo_in = rv;
    chk("R1 ready idle", req_ready, 1);
    if (ext && !is_w) last_rd = rv;
    e.rd = last_rd; e.ext = ext; e.len = 6 * k;
    sb.push_back(e);
    @(posedge clk); @(negedge clk);
    // R10 / R3: disturb inputs after acceptance
    dbl_speed = ~dbl; req_addr = ~addr; req_wdata = ~wd;
    for (int s = 0; s < 6; s++) begin
      for (int t = 0; t < k; t++) begin
        if (s == 5) lo_in = ~rv;
        else lo_in = rv;
        chk("R1 ready busy", req_ready, 0);
        chk("R3 high byte", hi_out, addr[15:8]);
        chk("R4 ale", ale, ext && s == 0);
        chk("R4 R5 R6 lo_oe", lo_oe, ext && (s <= 1 || is_w));
        if (ext && s <= 1) chk("R4 low address", lo_out, addr[7:0]);
        if (ext && is_w && s >= 2) chk("R6 write data", lo_out, wd);
        chk("R8 psen_n", psen_n, !(ext && is_c && s >= 2 && s <= 4));
        chk("R7 rd_n", rd_n, !(is_r && s >= 2 && s <= 4));
        chk("R6 wr_n", wr_n, !(is_w && s >= 2 && s <= 4));
        chk("R2 R12 done", done, (s == 5 && t == k - 1));
        @(posedge clk); @(negedge clk);
      end
    end
    req_valid = 0;
    chk("R1 ready after done", req_ready, 1);
    chk("R12 done single", done, 0);
    chk("R11 idle strobes", {ale, rd_n, wr_n, psen_n, lo_oe}, 5'b01110);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_wdata = 0; req_kind = 0;
    dbl_speed = 0; force_ext_n = 1; lo_in = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset strobes", {ale, rd_n, wr_n, psen_n, lo_oe, done}, 6'b011100);
    chk("R1 ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    run_cycle(2'd1, 16'h12A5, 8'h00, 0, 1, 8'h5C);  // R7 read, standard
    run_cycle(2'd1, 16'hFE01, 8'h00, 1, 1, 8'hC3);  // R7 read, double speed
    run_cycle(2'd2, 16'h3456, 8'h9B, 0, 1, 8'h11);  // R6 write, standard
    run_cycle(2'd2, 16'h80FF, 8'h64, 1, 1, 8'h22);  // R6 write, double speed
    run_cycle(2'd0, 16'h0000, 8'h00, 0, 0, 8'hE7);  // R9 forced off-chip at 0
    run_cycle(2'd0, 16'h0100, 8'h00, 0, 1, 8'hAA);  // R9 internal fetch
    run_cycle(2'd0, 16'h1FFF, 8'h00, 1, 1, 8'h99);  // R9 internal boundary
    run_cycle(2'd0, 16'h2000, 8'h00, 1, 1, 8'h3D);  // R8 fetch above limit
    run_cycle(2'd0, 16'h9ABC, 8'h00, 0, 0, 8'h81);  // R8 fetch standard
    run_cycle(2'd3, 16'h4321, 8'h00, 0, 1, 8'h0F);  // R7 reserved kind
    repeat (2) @(negedge clk);
    chk("R2 scoreboard empty", sb.size(), 0);
    finish_run();
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule